// File: doc/BRIEF.md
# Three-Wire Capable SPI Port

This block is a single-mode (sample on rising clock, change on falling clock) SPI port that can act as a bus master or a bus slave. It moves 8-bit words, most significant bit first. Software pushes words into a transmit queue and pops received words from a receive queue. Each queue has a level output and a threshold interrupt. Four-wire or three-wire pin use is selected by a configuration input. In three-wire operation one data pad carries both directions. The transmit path is also looped into the receive path, so a word the port sends comes back to it as a received word. A talk input decides whether that shared pad is driven at all.

As master, the port starts a transfer whenever its transmit queue holds a word. It pops the word, pulls its select line low for exactly one word, and divides the system clock by `DIV` to make the serial clock. In three-wire mode, a read is a transfer of a dummy word with talk cleared. The clock still runs, but the shared pad stays undriven, so the returning bits are captured.

As slave, the port synchronises the incoming clock and select. It loads its outgoing word (or zero when the queue is empty) when select falls. It samples on rising edges and shifts on falling edges.

The engine is one state machine with these states:
- `S_IDLE`: master waiting. Goes to `S_SETUP` when the transmit queue is non-empty. Goes to `S_SLAVE` when master is deselected.
- `S_SETUP`: select low, first bit presented. Goes to `S_HIGH` after a half period.
- `S_HIGH`: clock high. A bit is sampled on entry. After a half period it goes to `S_LOW`, or to `S_FINISH` after the last bit.
- `S_LOW`: clock low, next bit shifted out. Goes to `S_HIGH` after a half period.
- `S_FINISH`: holds select low for a half period. It then pushes the received word and returns to `S_IDLE`.
- `S_SLAVE`: follows the external pins. Returns to `S_IDLE` when master is selected.

Top module: `spi3w_port`

## Requirements
- R1: After reset, `ss_n_o` is 1, `sclk_o` is 0, both data output enables are 0, both levels are 0, and both interrupts are 0 while their enables are 0.
- R2: As master, each queued word is sent MSB first on `mosi_o`. Each transfer holds `ss_n_o` low for 2·DIV/2 + 8·DIV/2 + 7·DIV/2 system cycles with exactly 8 rising serial clock edges. Bits sampled on `miso_i` (four-wire) become one entry in the receive queue.
- R3: While the master serial clock is high, the outgoing data bit does not change.
- R4: The master serial clock stays high for DIV/2 system cycles per bit (8·DIV/2 high cycles per word).
- R5: In four-wire mode the talk input has no effect: the master drives `mosi_oe` for every cycle that select is low, and the slave drives `miso_oe` while its select is low.
- R6: In three-wire master mode with talk set, `mosi` is the shared pad and is driven, `miso_oe` stays 0, and the received word equals the transmitted word regardless of `miso_i`.
- R7: In three-wire master mode with talk cleared, `mosi_oe` stays 0 for the whole word, the clock still runs, and the received word is what arrived on `mosi_i`.
- R8: As slave in four-wire mode, the head of the transmit queue (or 0x00 when it is empty) is shifted out on `miso_o`, bits from `mosi_i` are received, and `sclk_oe` and `ss_n_oe` are 0.
- R9: In three-wire slave mode, `miso` is the shared pad and `mosi_oe` is 0. With talk set, the pad is driven and the port receives its own word. With talk cleared, the pad is not driven and the word on `miso_i` is received.
- R10: A slave ignores clock edges while select is high, and it restarts its bit count when select returns high. A partial word is discarded.
- R11: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and the receive level is at least `rx_thresh`.
- R12: `tx_irq` is 1 exactly when `tx_irq_en` is 1 and the transmit level is at most `tx_thresh`.
- R13: Each queue holds DEPTH words in order. A push into a full queue is dropped. A push and a pop in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_three_wire | input | 1 | 1 = one shared data pad |
| cfg_talk | input | 1 | Allows the shared pad to be driven in three-wire mode |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | WORD | Word to transmit |
| rd_en | input | 1 | Pop the receive queue head |
| rd_data | output | WORD | Receive queue head |
| tx_level | output | LW | Transmit queue fill level |
| rx_level | output | LW | Receive queue fill level |
| tx_thresh | input | LW | Transmit interrupt threshold |
| rx_thresh | input | LW | Receive interrupt threshold |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq | output | 1 | Transmit level at or below threshold |
| rx_irq | output | 1 | Receive level at or above threshold |
| sclk_i | input | 1 | Serial clock pad input |
| sclk_o | output | 1 | Serial clock pad output |
| sclk_oe | output | 1 | Serial clock pad enable |
| ss_n_i | input | 1 | Select pad input, active low |
| ss_n_o | output | 1 | Select pad output, active low |
| ss_n_oe | output | 1 | Select pad enable |
| mosi_i | input | 1 | Master-to-slave pad input |
| mosi_o | output | 1 | Master-to-slave pad output |
| mosi_oe | output | 1 | Master-to-slave pad enable |
| miso_i | input | 1 | Slave-to-master pad input |
| miso_o | output | 1 | Slave-to-master pad output |
| miso_oe | output | 1 | Slave-to-master pad enable |

## Verification
Two functions can land in the same clock edge: a host write into the transmit queue and the engine popping that queue's head to start a transfer. The bench provokes this with two writes on consecutive cycles into an idle master. The engine takes the first word in the cycle the second one arrives. The level must then read 1, not 2 or 0. Both words must later leave the pad in write order, and both replies must reach the receive queue.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_HIGH,
        S_LOW,
        S_FINISH,
        S_SLAVE
    } eng_state_t;
endpackage

// File: rtl/spi3w_fifo.sv
module spi3w_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_pop  = pop && (level != '0);
    assign do_push = push && ((level != LW'(DEPTH)) || do_pop);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    // R13: level never exceeds capacity
    a_r13_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R13: a lone push into a full queue is dropped
    a_r13_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && push && !pop) |=> $stable(level));
endmodule

// File: rtl/spi3w_engine.sv
module spi3w_engine
    import spi3w_pkg::*;
#(
    parameter int WORD  = 8,
    parameter int DIV   = 4,
    localparam int HALF = DIV / 2,
    localparam int CNTW = $clog2(HALF + 1),
    localparam int BW   = $clog2(WORD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_master,
    input  logic            tx_valid,
    input  logic [WORD-1:0] tx_word,
    input  logic            din,
    input  logic            sclk_i,
    input  logic            ss_n_i,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [WORD-1:0] rx_word,
    output logic            dout,
    output logic            sclk_o,
    output logic            ss_n_o,
    output logic            slave_sel
);
    eng_state_t      state, nxt;
    logic [CNTW-1:0] cnt;
    logic [BW-1:0]   bitn;
    logic [WORD-1:0] tx_sh, rx_sh;
    logic [1:0]      sclk_sync, ss_sync;
    logic            sclk_prev, ss_prev;
    logic            sclk_s, ss_s, half_done, last_bit;
    logic            s_rise, s_fall, s_load;
    logic [BW:0]     edge_cnt;

    assign sclk_s    = sclk_sync[1];
    assign ss_s      = ss_sync[1];
    assign half_done = (cnt == CNTW'(HALF - 1));
    assign last_bit  = (bitn == BW'(WORD - 1));
    assign s_rise    = (state == S_SLAVE) && !ss_s && sclk_s && !sclk_prev;
    assign s_fall    = (state == S_SLAVE) && !ss_s && !sclk_s && sclk_prev;
    assign s_load    = (state == S_SLAVE) && !ss_s && ss_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (!cfg_master)   nxt = S_SLAVE;
                      else if (tx_valid) nxt = S_SETUP;
            S_SETUP:  if (half_done)     nxt = S_HIGH;
            S_HIGH:   if (half_done)     nxt = last_bit ? S_FINISH : S_LOW;
            S_LOW:    if (half_done)     nxt = S_HIGH;
            S_FINISH: if (half_done)     nxt = S_IDLE;
            S_SLAVE:  if (cfg_master)    nxt = S_IDLE;
            default:                     nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk_o    = (state == S_HIGH);
        ss_n_o    = (state == S_IDLE) || (state == S_SLAVE);
        dout      = tx_sh[WORD-1];
        slave_sel = (state == S_SLAVE) && !ss_s;
        tx_pop    = tx_valid && (((state == S_IDLE) && cfg_master) || s_load);
        rx_push   = ((state == S_FINISH) && half_done) || (s_rise && last_bit);
        rx_word   = (state == S_SLAVE) ? {rx_sh[WORD-2:0], din} : rx_sh;
    end

    // pin synchronisers for slave operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync <= 2'b00;
            ss_sync   <= 2'b11;
            sclk_prev <= 1'b0;
            ss_prev   <= 1'b1;
        end else begin
            sclk_sync <= {sclk_sync[0], sclk_i};
            ss_sync   <= {ss_sync[0], ss_n_i};
            sclk_prev <= sclk_s;
            ss_prev   <= ss_s;
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bitn  <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (nxt != state || state == S_IDLE || state == S_SLAVE) cnt <= '0;
            else cnt <= cnt + CNTW'(1);

            if (state == S_SLAVE) begin
                if (ss_s) begin
                    bitn <= '0;
                end else if (s_load) begin
                    tx_sh <= tx_valid ? tx_word : '0;
                    bitn  <= '0;
                end else begin
                    if (s_rise) begin
                        rx_sh <= {rx_sh[WORD-2:0], din};
                        bitn  <= last_bit ? '0 : bitn + BW'(1);
                    end
                    if (s_fall) tx_sh <= {tx_sh[WORD-2:0], 1'b0};
                end
            end else begin
                if (state == S_IDLE && nxt == S_SETUP) begin
                    tx_sh <= tx_word;
                    bitn  <= '0;
                end else if (state == S_HIGH && nxt == S_LOW) begin
                    tx_sh <= {tx_sh[WORD-2:0], 1'b0};
                    bitn  <= bitn + BW'(1);
                end
                if (nxt == S_HIGH && state != S_HIGH) rx_sh <= {rx_sh[WORD-2:0], din};
            end
        end
    end

    // checker counter: rising edges of the master clock in this word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                edge_cnt <= '0;
        else if (state == S_IDLE)                  edge_cnt <= '0;
        else if (nxt == S_HIGH && state != S_HIGH) edge_cnt <= edge_cnt + (BW + 1)'(1);
    end

    // R2: a master word carries exactly WORD rising edges
    a_r2_edge_total: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FINISH) |-> (edge_cnt == (BW + 1)'(WORD)));
    // R3: data is frozen while the master clock is high
    a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH && $past(state) == S_HIGH) |-> $stable(dout));
    // R10: deselected slave keeps its bit count at zero
    a_r10_bit_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLAVE && ss_s && !cfg_master) |=> (bitn == '0));
endmodule

// File: rtl/spi3w_port.sv
module spi3w_port
    import spi3w_pkg::*;
#(
    parameter int WORD  = 8,
    parameter int DIV   = 4,
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_master,
    input  logic            cfg_three_wire,
    input  logic            cfg_talk,
    input  logic            wr_en,
    input  logic [WORD-1:0] wr_data,
    input  logic            rd_en,
    output logic [WORD-1:0] rd_data,
    output logic [LW-1:0]   tx_level,
    output logic [LW-1:0]   rx_level,
    input  logic [LW-1:0]   tx_thresh,
    input  logic [LW-1:0]   rx_thresh,
    input  logic            tx_irq_en,
    input  logic            rx_irq_en,
    output logic            tx_irq,
    output logic            rx_irq,
    input  logic            sclk_i,
    output logic            sclk_o,
    output logic            sclk_oe,
    input  logic            ss_n_i,
    output logic            ss_n_o,
    output logic            ss_n_oe,
    input  logic            mosi_i,
    output logic            mosi_o,
    output logic            mosi_oe,
    input  logic            miso_i,
    output logic            miso_o,
    output logic            miso_oe
);
    logic            tx_pop, rx_push, dout, din, shared_in, drive_ok, slave_sel;
    logic [WORD-1:0] tx_head, rx_word;

    spi3w_fifo #(.W(WORD), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(tx_pop), .head(tx_head), .level(tx_level)
    );

    spi3w_fifo #(.W(WORD), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rd_en), .head(rd_data), .level(rx_level)
    );

    spi3w_engine #(.WORD(WORD), .DIV(DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .tx_valid(tx_level != '0), .tx_word(tx_head), .din(din),
        .sclk_i(sclk_i), .ss_n_i(ss_n_i), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_word(rx_word), .dout(dout), .sclk_o(sclk_o), .ss_n_o(ss_n_o),
        .slave_sel(slave_sel)
    );

    // pad steering and receive source
    always_comb begin
        shared_in = cfg_master ? mosi_i : miso_i;
        drive_ok  = !cfg_three_wire || cfg_talk;
        if (cfg_three_wire) din = cfg_talk ? dout : shared_in;
        else                din = cfg_master ? miso_i : mosi_i;
        mosi_o  = dout;
        miso_o  = dout;
        mosi_oe = cfg_master && !ss_n_o && drive_ok;
        miso_oe = !cfg_master && slave_sel && drive_ok;
        sclk_oe = cfg_master;
        ss_n_oe = cfg_master;
        rx_irq  = rx_irq_en && (rx_level >= rx_thresh);
        tx_irq  = tx_irq_en && (tx_level <= tx_thresh);
    end

    // R7: listening in three-wire mode leaves both data pads undriven
    a_r7_quiet_pads: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_three_wire && !cfg_talk) |-> (!mosi_oe && !miso_oe));
    // R6: three-wire master never drives the spare pad
    a_r6_spare_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_three_wire && cfg_master) |-> !miso_oe);
    // R5: four-wire master drives data whenever its select is low
    a_r5_always_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !cfg_three_wire && !ss_n_o) |-> mosi_oe);
endmodule

// File: tb/test_spi3w_port.sv
module test_spi3w_port;
    localparam int WORD = 8, DIV = 4, DEPTH = 4, LW = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_master = 1'b1, cfg_three_wire = 1'b0, cfg_talk = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [WORD-1:0] wr_data = '0, rd_data;
    logic [LW-1:0] tx_level, rx_level, tx_thresh = '0, rx_thresh = '0;
    logic tx_irq_en = 1'b0, rx_irq_en = 1'b0, tx_irq, rx_irq;
    logic sclk_o, sclk_oe, ss_n_o, ss_n_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic slv_sclk = 1'b0, slv_ss = 1'b1, slv_a = 1'b0, slv_b = 1'b0;
    logic mosi_i, miso_i;

    int checks = 0, errors = 0;

    // external slave model for master tests
    logic [7:0] ext_word = '0, ext_sh = '0, cap = '0;
    int rises = 0, oe_cyc = 0, low_cyc = 0, high_cyc = 0, boe = 0;
    logic prev_ss = 1'b1, prev_sclk = 1'b0;

    assign mosi_i = cfg_master ? ext_sh[7] : slv_a;
    assign miso_i = cfg_master ? ext_sh[7] : slv_b;

    always #4 clk = ~clk;

    spi3w_port #(.WORD(WORD), .DIV(DIV), .DEPTH(DEPTH)) i_spi3w_port (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
        .cfg_three_wire(cfg_three_wire), .cfg_talk(cfg_talk),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_thresh(tx_thresh),
        .rx_thresh(rx_thresh), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_i(slv_sclk), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .ss_n_i(slv_ss), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    always @(negedge clk) begin
        if (prev_ss && !ss_n_o) begin
            ext_sh = ext_word; cap = '0; rises = 0;
            oe_cyc = 0; low_cyc = 0; high_cyc = 0; boe = 0;
        end
        if (!ss_n_o) begin
            low_cyc++;
            if (mosi_oe) oe_cyc++;
            if (sclk_o) high_cyc++;
            if (miso_oe) boe++;
        end
        if (!prev_sclk && sclk_o) begin cap = {cap[6:0], mosi_o}; rises++; end
        if (prev_sclk && !sclk_o) ext_sh = {ext_sh[6:0], 1'b0};
        prev_ss = ss_n_o; prev_sclk = sclk_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [7:0] w);
        @(negedge clk) begin wr_en = 1'b1; wr_data = w; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pop_rx();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic drain_rx();
        for (int k = 0; k < 8 && rx_level != '0; k++) pop_rx();
    endtask

    task automatic wait_master_done();
        for (int k = 0; k < 60 && ss_n_o; k++) @(negedge clk);
        for (int k = 0; k < 200 && !ss_n_o; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic slave_xfer(input logic [7:0] mosi, output logic [7:0] miso, output int oe_n);
        miso = '0; oe_n = 0;
        @(negedge clk) slv_ss = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            slv_a = mosi[i]; slv_b = mosi[i];
            repeat (4) @(negedge clk);
            slv_sclk = 1'b1;
            repeat (2) @(negedge clk);
            miso[i] = miso_o;
            if (miso_oe) oe_n++;
            repeat (2) @(negedge clk);
            slv_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        slv_ss = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // {three_wire, talk, transmit word, word presented by the far end}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 1'b1, 8'hA5, 8'h3C},
        {1'b0, 1'b0, 8'h5A, 8'hC3},
        {1'b0, 1'b1, 8'h00, 8'hFF},
        {1'b0, 1'b1, 8'hFF, 8'h00},
        {1'b1, 1'b1, 8'h96, 8'h0F},
        {1'b1, 1'b1, 8'h01, 8'h80},
        {1'b1, 1'b0, 8'h77, 8'hE2},
        {1'b1, 1'b0, 8'h00, 8'h81}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete act=0 exp=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] miso;
        int oe_n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ss_n_o", ss_n_o, 1);
        chk("R1 sclk_o", sclk_o, 0);
        chk("R1 data oe", {mosi_oe, miso_oe}, 0);
        chk("R1 levels", {tx_level, rx_level}, 0);
        chk("R1 irqs", {tx_irq, rx_irq}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: master transfers
        for (int v = 0; v < 8; v++) begin
            logic tw, tk;
            logic [7:0] txw, exw, exp_rx;
            tw = VEC[v][17]; tk = VEC[v][16]; txw = VEC[v][15:8]; exw = VEC[v][7:0];
            exp_rx = (tw && tk) ? txw : exw;
            @(negedge clk) begin cfg_master = 1'b1; cfg_three_wire = tw; cfg_talk = tk; ext_word = exw; end
            write_word(txw);
            wait_master_done();
            chk(tw ? (tk ? "R6 loopback rx" : "R7 listen rx") : "R2 rx word", rd_data, exp_rx);
            chk("R2 rising edges", rises, 8);
            chk("R2 select length", low_cyc, 17 * (DIV / 2));
            chk("R4 clock high cycles", high_cyc, 8 * (DIV / 2));
            chk(tw ? (tk ? "R6 drive cycles" : "R7 no drive") : "R5 talk ignored", oe_cyc,
                (!tw || tk) ? 17 * (DIV / 2) : 0);
            if (!tw || tk) chk("R2 MSB-first on pad", cap, txw);
            chk("R6 spare pad undriven", boe, 0);
            chk("R2 one rx entry", rx_level, 1);
            pop_rx();
        end

        // R13 simultaneous push and engine pop
        @(negedge clk) begin cfg_three_wire = 1'b0; cfg_talk = 1'b1; ext_word = 8'h5C; wr_en = 1'b1; wr_data = 8'h11; end
        @(negedge clk) wr_data = 8'h22;
        @(negedge clk) wr_en = 1'b0;
        chk("R13 push+pop level", tx_level, 1);
        wait_master_done();
        wait_master_done();
        chk("R13 both replies", rx_level, 2);
        chk("R13 order on pad", cap, 8'h22);
        drain_rx();

        // slave mode
        @(negedge clk) begin cfg_master = 1'b0; cfg_three_wire = 1'b0; cfg_talk = 1'b0; end
        repeat (2) @(negedge clk);
        chk("R8 pins released", {sclk_oe, ss_n_oe}, 0);
        write_word(8'hC4);
        slave_xfer(8'h3B, miso, oe_n);
        chk("R8 slave out", miso, 8'hC4);
        chk("R5 slave drives talk=0", oe_n, 8);
        chk("R8 slave rx", rd_data, 8'h3B);
        drain_rx();

        @(negedge clk) begin cfg_three_wire = 1'b1; cfg_talk = 1'b1; end
        write_word(8'h6D);
        slave_xfer(8'h12, miso, oe_n);
        chk("R9 shared drive", oe_n, 8);
        chk("R9 slave out", miso, 8'h6D);
        chk("R9 own word back", rd_data, 8'h6D);
        chk("R9 mosi pad idle", mosi_oe, 0);
        drain_rx();

        @(negedge clk) cfg_talk = 1'b0;
        write_word(8'hAA);
        slave_xfer(8'h4E, miso, oe_n);
        chk("R9 listen undriven", oe_n, 0);
        chk("R9 listen rx", rd_data, 8'h4E);
        drain_rx();

        // R10 clocks ignored while deselected, partial word dropped
        @(negedge clk) begin cfg_three_wire = 1'b0; slv_a = 1'b1; end
        for (int k = 0; k < 5; k++) begin
            repeat (4) @(negedge clk); slv_sclk = 1'b1;
            repeat (4) @(negedge clk); slv_sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk("R10 deselected clocks", rx_level, 0);
        @(negedge clk) slv_ss = 1'b0;
        repeat (6) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            repeat (4) @(negedge clk); slv_sclk = 1'b1;
            repeat (4) @(negedge clk); slv_sclk = 1'b0;
        end
        repeat (4) @(negedge clk); slv_ss = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 partial dropped", rx_level, 0);
        slave_xfer(8'h81, miso, oe_n);
        chk("R10 realigned word", rd_data, 8'h81);
        chk("R8 empty queue sends zero", miso, 8'h00);
        drain_rx();

        // R11 receive threshold
        @(negedge clk) begin rx_thresh = LW'(2); rx_irq_en = 1'b1; end
        slave_xfer(8'h01, miso, oe_n);
        chk("R11 below threshold", rx_irq, 0);
        slave_xfer(8'h02, miso, oe_n);
        chk("R11 at threshold", rx_irq, 1);
        @(negedge clk) rx_irq_en = 1'b0;
        @(negedge clk);
        chk("R11 disabled", rx_irq, 0);
        drain_rx();

        // R12 transmit threshold
        @(negedge clk) begin tx_thresh = LW'(1); tx_irq_en = 1'b1; end
        @(negedge clk);
        chk("R12 empty at threshold", tx_irq, 1);
        write_word(8'h31);
        write_word(8'h32);
        chk("R12 above threshold", tx_irq, 0);
        slave_xfer(8'h00, miso, oe_n);
        chk("R12 dropped to threshold", tx_irq, 1);
        @(negedge clk) tx_irq_en = 1'b0;
        @(negedge clk);
        chk("R12 disabled", tx_irq, 0);
        slave_xfer(8'h00, miso, oe_n);
        drain_rx();

        // R13 overflow on both queues
        for (int k = 0; k < 5; k++) write_word(8'hA1 + 8'(k));
        chk("R13 tx full drop", tx_level, 4);
        for (int k = 0; k < 4; k++) slave_xfer(8'h10 + 8'(k), miso, oe_n);
        chk("R13 fourth word out", miso, 8'hA4);
        chk("R13 tx drained", tx_level, 0);
        slave_xfer(8'h99, miso, oe_n);
        chk("R13 rx full drop", rx_level, 4);
        chk("R13 rx head kept", rd_data, 8'h10);
        drain_rx();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule